// File: doc/BRIEF.md
# Comparator-Stepped Offset Null Controller

This block cancels the DC offset of an analog gain stage. A correction DAC feeds a small voltage back into the stage, and a comparator reports only the sign of what is left. The controller sets the DAC code, waits for the analog path to settle, and reads the comparator. It then moves the code one LSB toward the null and repeats.

A run starts from mid-scale on a start pulse and ends in one of three ways. It converges when the comparator sign flips between two decisions. It saturates when the next step would leave the code range. It times out when a cap on the number of decisions is reached. The settle wait is a run-time input, so the same logic can be used with analog paths of different speeds. The comparator is an asynchronous input and passes through a two-flop synchronizer.

Top module: `offset_null_ctrl`

## Requirements
- R1: While reset is high at a clock edge, the controller goes idle. `dac_code` becomes mid-scale (bit CODE_W-1 set, all other bits clear), and `busy`, `done`, `sat`, `tmo` and `code_vld` all go low.
- R2: A `start` seen at a clock edge while idle does four things at that edge: it loads mid-scale into `dac_code`, raises `busy`, clears `done`, `sat` and `tmo`, and pulses `code_vld` for one cycle.
- R3: At each decision, a synchronized comparator value of 1 raises `dac_code` by exactly one, and a value of 0 lowers it by exactly one. The code never changes by more than one per cycle while busy.
- R4: The first decision falls `settle_cycles`+1 clock edges after the start edge. Each later decision falls `settle_cycles`+1 edges after the previous step. The comparator is sampled through a two-flop synchronizer.
- R5: A decision whose comparator value differs from the previous decision's value ends the run. It leaves `dac_code` unchanged, raises `done` and drops `busy`.
- R6: A decision that would move the code below 0 or above 2^CODE_W-1 ends the run. It raises `sat` and `done` and leaves the code clamped at that limit.
- R7: The MAX_DEC-th decision of a run, if it is neither a reversal nor a saturation, ends the run with `tmo` and `done` raised and the code unchanged. The code is then mid-scale ±(MAX_DEC-1).
- R8: `start` has no effect while `busy` is high.
- R9: While idle and without `start`, `dac_code` holds its value, and `done`, `sat` and `tmo` hold until the next start or reset, whatever the comparator does.
- R10: `code_vld` pulses for one cycle in exactly those cycles in which a new code appears: the start load and each step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a calibration run (ignored while busy) |
| cmp_in | input | 1 | Comparator: 1 = code too low, 0 = code too high |
| settle_cycles | input | CNT_W | Settle wait; decisions are settle_cycles+1 cycles apart |
| dac_code | output | CODE_W | Correction DAC code |
| code_vld | output | 1 | One-cycle pulse when a new code is presented |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held) |
| sat | output | 1 | Run ended at a code limit |
| tmo | output | 1 | Run ended on the decision cap |

## Verification
The bench builds two instances with an 8-bit code, so mid-scale is 128. This makes saturation at both 0 and 255 reachable within a few hundred decisions. The first instance keeps a generous decision cap. The second uses a cap of 20, which brings the timeout path within reach: a distant offset reaches the cap long before it could saturate. A comparator model inside the bench closes the loop around each instance, with a settle wait of at least two cycles so the synchronizer delay is covered.

// File: rtl/offset_null_ctrl.sv
module offset_null_ctrl #(
  parameter int CODE_W  = 16,
  parameter int CNT_W   = 16,
  parameter int MAX_DEC = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmp_in,
  input  logic [CNT_W-1:0]  settle_cycles,
  output logic [CODE_W-1:0] dac_code,
  output logic              code_vld,
  output logic              busy,
  output logic              done,
  output logic              sat,
  output logic              tmo
);
  localparam int DEC_W = $clog2(MAX_DEC + 1);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [DEC_W-1:0] LAST_DEC = DEC_W'(MAX_DEC - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] wait_cnt;
  logic [DEC_W-1:0] n_dec;
  logic             first, last_up;

  wire up     = sync_q[1];
  wire due    = wait_cnt >= settle_cycles;
  wire flip   = !first && (up != last_up);
  wire at_lim = up ? (dac_code == {CODE_W{1'b1}}) : (dac_code == '0);
  wire capped = n_dec == LAST_DEC;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[0], cmp_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= MID;
      code_vld <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      sat      <= 1'b0;
      tmo      <= 1'b0;
      wait_cnt <= '0;
      n_dec    <= '0;
      first    <= 1'b1;
      last_up  <= 1'b0;
    end else begin
      code_vld <= 1'b0;
      if (start && !busy) begin
        dac_code <= MID;
        code_vld <= 1'b1;
        busy     <= 1'b1;
        done     <= 1'b0;
        sat      <= 1'b0;
        tmo      <= 1'b0;
        wait_cnt <= '0;
        n_dec    <= '0;
        first    <= 1'b1;
      end else if (busy) begin
        if (!due) begin
          wait_cnt <= wait_cnt + 1'b1;
        end else if (flip) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (at_lim) begin
          busy <= 1'b0;
          done <= 1'b1;
          sat  <= 1'b1;
        end else if (capped) begin
          busy <= 1'b0;
          done <= 1'b1;
          tmo  <= 1'b1;
        end else begin
          dac_code <= up ? dac_code + 1'b1 : dac_code - 1'b1;
          code_vld <= 1'b1;
          wait_cnt <= '0;
          n_dec    <= n_dec + 1'b1;
          first    <= 1'b0;
          last_up  <= up;
        end
      end
    end
  end
endmodule

module offset_null_ctrl_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CODE_W-1:0] dac_code,
  input logic              code_vld,
  input logic              busy,
  input logic              done,
  input logic              sat,
  input logic              tmo
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && code_vld && dac_code == MID && !done && !sat && !tmo));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (dac_code == $past(dac_code) || dac_code == $past(dac_code) + 1'b1
              || dac_code == $past(dac_code) - 1'b1));

  // R6
  sat_limit_chk: assert property (@(posedge clk) disable iff (rst)
    sat |-> (done && !busy && (dac_code == '0 || dac_code == {CODE_W{1'b1}})));

  // R7
  tmo_flag_chk: assert property (@(posedge clk) disable iff (rst)
    tmo |-> (done && !busy && !sat));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(dac_code) && $stable(done) && $stable(sat) && $stable(tmo)));

  // R10
  vld_busy_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> busy);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind offset_null_ctrl offset_null_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .dac_code(dac_code), .code_vld(code_vld),
  .busy(busy), .done(done), .sat(sat), .tmo(tmo)
);

// File: tb/sim_offset_null_ctrl.sv
`timescale 1ns/1ps
module sim_offset_null_ctrl;
  localparam int W = 8;
  localparam int N = 7;
  localparam int TGT[N]  = '{200, 129, 128, 60, 1, 0, 256};
  localparam int EXPC[N] = '{200, 129, 127, 59, 0, 0, 255};
  localparam int EXPS[N] = '{0, 0, 0, 0, 0, 1, 1};

  logic clk = 0, rst = 1;
  logic st0 = 0, st1 = 0;
  logic [15:0] s0 = 16'd3, s1 = 16'd3;
  int tgt0 = 128, tgt1 = 128;
  logic [W-1:0] c0, c1;
  logic v0, b0, d0, sa0, t0, v1, b1, d1, sa1, t1;
  int checks = 0, errors = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  wire cmp0 = int'(c0) < tgt0;
  wire cmp1 = int'(c1) < tgt1;

  offset_null_ctrl #(.CODE_W(W), .CNT_W(16), .MAX_DEC(1000)) u0 (
    .clk(clk), .rst(rst), .start(st0), .cmp_in(cmp0), .settle_cycles(s0),
    .dac_code(c0), .code_vld(v0), .busy(b0), .done(d0), .sat(sa0), .tmo(t0));

  offset_null_ctrl #(.CODE_W(W), .CNT_W(16), .MAX_DEC(20)) u1 (
    .clk(clk), .rst(rst), .start(st1), .cmp_in(cmp1), .settle_cycles(s1),
    .dac_code(c1), .code_vld(v1), .busy(b1), .done(d1), .sat(sa1), .tmo(t1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done0();
    for (int i = 0; i < 5000 && !d0; i++) @(negedge clk);
  endtask

  task automatic wait_done1();
    for (int i = 0; i < 5000 && !d1; i++) @(negedge clk);
  endtask

  task automatic pulse0();
    @(negedge clk) st0 = 1;
    @(negedge clk) st0 = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k, first_k, second_k;
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(c0 == 128 && !b0 && !d0 && !sa0 && !t0 && !v0, "R1 reset", int'(c0), 128);

    // R4 R10 R2 timing with settle 6, target 130
    s0 = 16'd6; tgt0 = 130;
    pulse0();
    chk(v0 && b0 && c0 == 128 && !d0, "R2 start load", int'(c0), 128);
    first_k = 0; second_k = 0; prev = c0;
    for (int j = 1; j <= 30 && second_k == 0; j++) begin
      @(negedge clk);
      if (j == 1) chk(!v0, "R10 single pulse", int'(v0), 0);
      if (c0 != prev) begin
        chk(v0, "R10 vld on step", int'(v0), 1);
        if (first_k == 0) first_k = j; else second_k = j;
        prev = c0;
      end
    end
    chk(first_k == 7, "R4 first decision", first_k, 7);
    chk(second_k - first_k == 7, "R4 step spacing", second_k - first_k, 7);
    wait_done0();
    chk(d0 && !b0 && c0 == 130 && !sa0, "R5 converge", int'(c0), 130);

    // R3 R5 R6 table sweep
    s0 = 16'd3;
    for (int i = 0; i < N; i++) begin
      tgt0 = TGT[i];
      pulse0();
      chk(!d0 && b0, "R2 done cleared", int'(d0), 0);
      wait_done0();
      chk(int'(c0) == EXPC[i], EXPS[i] ? "R6 clamp code" : "R3 R5 final code", int'(c0), EXPC[i]);
      chk(sa0 == EXPS[i][0], "R6 sat flag", int'(sa0), EXPS[i]);
      chk(!t0 && !b0, "R5 no timeout", int'(t0), 0);
    end

    // R9 idle hold while comparator toggles
    prev = c0;
    for (int j = 0; j < 10; j++) begin
      tgt0 = (j % 2) ? 0 : 256;
      @(negedge clk);
    end
    chk(c0 == prev && d0 && sa0, "R9 idle hold", int'(c0), int'(prev));

    // R8 start while busy ignored
    tgt0 = 200;
    pulse0();
    repeat (20) @(negedge clk);
    prev = c0;
    pulse0();
    chk(c0 >= prev && c0 != 128, "R8 start ignored", int'(c0), int'(prev));
    wait_done0();
    chk(c0 == 200 && d0, "R8 run completes", int'(c0), 200);

    // R1 reset mid-run
    tgt0 = 20;
    pulse0();
    repeat (30) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(c0 == 128 && !b0 && !d0 && !v0, "R1 reset mid-run", int'(c0), 128);

    // R7 timeout on u1
    tgt1 = 200;
    @(negedge clk) st1 = 1;
    @(negedge clk) st1 = 0;
    wait_done1();
    chk(t1 && d1 && !sa1, "R7 tmo flag", int'(t1), 1);
    chk(c1 == 147, "R7 tmo code", int'(c1), 147);
    tgt1 = 140;
    @(negedge clk) st1 = 1;
    @(negedge clk) st1 = 0;
    chk(!t1, "R2 tmo cleared", int'(t1), 0);
    wait_done1();
    chk(!t1 && c1 == 140, "R7 under cap", int'(c1), 140);

    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule